// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

This block is one timer channel behind a 32-bit word-addressed register port. A programmable prescaler divides the block clock by a divisor of at least two. Each divided tick advances a 28-bit up-counter. When the next tick would take the counter to the programmed period value, the channel expires and raises a pending flag. It then either wraps to zero and keeps running, or halts, depending on a mode bit.

The interrupt line is high whenever the pending flag and the interrupt enable are both set. Software clears the flag by writing a one to it. Software may also load the counter at any time. A load takes effect at once and restarts the prescaler phase, so the next tick always comes a full divisor period after the load.

Top module: `tmr_channel`

## Requirements
- R1: Word offsets decode from `bus_addr[3:2]`: 0x0 period (bits [27:0]), 0x4 live count (bits [27:0]), 0x8 control, 0xC interrupt. Bits with no function read as zero, so writing all ones reads back 0x0FFFFFFF from the period and 0x1100FFFF from the control word.
- R2: Control bit 28 enables counting. Writing zero to the control word stops the timer, and the count then keeps its value.
- R3: Control bits [15:0] hold the divisor D, and values 0 and 1 act as 2. After an enabling write, the count has advanced floor(n/D) times n clocks later.
- R4: Expiry is the tick on which count+1 equals the period value, taken modulo 2^28. Expiry sets the pending flag, interrupt bit 16.
- R5: With control bit 24 set (repeat), the count becomes 0 on the expiry tick and counting continues at the same rate.
- R6: With control bit 24 clear (one-shot), the count holds its value on expiry and control bit 28 reads back as 0.
- R7: `irq` is high exactly when the pending flag and the interrupt enable (interrupt bit 20) are both set.
- R8: Writing 1 to interrupt bit 16 clears the pending flag. Writing 0 there leaves the flag unchanged.
- R9: If an expiry and a clearing write fall in the same cycle, the pending flag ends up set.
- R10: A write to the count register loads the value on that clock edge and restarts the prescaler phase. The next increment comes D clocks later.
- R11: After reset, every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for the strobe |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt request, pending AND enable |

## Verification
A wrong prescaler phase appears at the count register within one divisor period. The bench therefore samples the count a set number of clocks after the enabling write or a count load, and one clock of skew moves the floor(n/D) result. A wrong expiry compare or a wrong mode decision shows up on the expiry edge itself. The pending bit, the enable readback and the count are all visible on the following read, because expiry occurs a known P*D clocks after enable. The set-versus-clear race is forced by placing a clearing write exactly on that edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BUS_W    = 32;
    localparam int EN_BIT   = 28;
    localparam int MODE_BIT = 24;
    localparam int IE_BIT   = 20;
    localparam int PEND_BIT = 16;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_INTR   = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic        run;
        logic        wrap;
        logic [15:0] div;
    } ctrl_t;

    function automatic logic [15:0] last_phase(input logic [15:0] div);
        return (div < 16'd2) ? 16'd1 : div - 16'd1;
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] last;

    always_comb begin
        last = (div < DIV_W'(2)) ? DIV_W'(1) : div - DIV_W'(1);
        tick = run && !restart && (phase_q == last);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart || tick) phase_q <= '0;
        else                                phase_q <= phase_q + DIV_W'(1);
    end

    // R3: divisor is at least two, so ticks never come back to back
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wrap,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] nxt;

    always_comb begin
        nxt    = count + CNT_W'(1);
        expire = tick && !load && (nxt == period);
    end

    always_ff @(posedge clk) begin
        if (rst)          count <= '0;
        else if (load)    count <= load_val;
        else if (expire)  count <= wrap ? '0 : count;
        else if (tick)    count <= nxt;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 28,
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    reg_sel_e         sel;
    logic             wr_period, wr_count, wr_ctrl, wr_intr;
    logic [CNT_W-1:0] period_q;
    logic             run_q, wrap_q;
    logic [DIV_W-1:0] div_q;
    logic             ie_q, pend_q;
    logic             tick, expire;
    logic [CNT_W-1:0] count;

    always_comb begin
        sel       = reg_sel_e'(bus_addr[3:2]);
        wr_period = bus_sel && bus_wr && (sel == SEL_PERIOD);
        wr_count  = bus_sel && bus_wr && (sel == SEL_COUNT);
        wr_ctrl   = bus_sel && bus_wr && (sel == SEL_CTRL);
        wr_intr   = bus_sel && bus_wr && (sel == SEL_INTR);
    end

    tmr_prescale #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .run(run_q), .restart(wr_count),
        .div(div_q), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .wrap(wrap_q),
        .load(wr_count), .load_val(bus_wdata[CNT_W-1:0]),
        .period(period_q), .count(count), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            run_q    <= 1'b0;
            wrap_q   <= 1'b0;
            div_q    <= '0;
            ie_q     <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (wr_period) period_q <= bus_wdata[CNT_W-1:0];
            if (wr_ctrl) begin
                run_q  <= bus_wdata[EN_BIT];
                wrap_q <= bus_wdata[MODE_BIT];
                div_q  <= bus_wdata[DIV_W-1:0];
            end else if (expire && !wrap_q) begin
                run_q  <= 1'b0;
            end
            if (wr_intr) ie_q <= bus_wdata[IE_BIT];
            if (expire)                              pend_q <= 1'b1;
            else if (wr_intr && bus_wdata[PEND_BIT]) pend_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_PERIOD: bus_rdata[CNT_W-1:0] = period_q;
            SEL_COUNT:  bus_rdata[CNT_W-1:0] = count;
            SEL_CTRL: begin
                bus_rdata[EN_BIT]      = run_q;
                bus_rdata[MODE_BIT]    = wrap_q;
                bus_rdata[DIV_W-1:0]   = div_q;
            end
            SEL_INTR: begin
                bus_rdata[IE_BIT]   = ie_q;
                bus_rdata[PEND_BIT] = pend_q;
            end
            default: bus_rdata = '0;
        endcase
        irq = pend_q && ie_q;
    end

    // R4: pending only rises after a counter expiry
    a_r4_pend_source: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(expire));
    // R9: expiry wins over a simultaneous clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        expire |=> pend_q);
    // R5: repeat mode wraps the count to zero
    a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
        (expire && wrap_q) |=> (count == '0));
    // R6: one-shot mode drops the enable and keeps the count
    a_r6_oneshot_halt: assert property (@(posedge clk) disable iff (rst)
        (expire && !wrap_q && !wr_ctrl) |=> (!run_q && $stable(count)));
    // R2: a stopped timer keeps its count
    a_r2_frozen: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !wr_count) |=> $stable(count));
    // R10: a count write lands on the next edge
    a_r10_load: assert property (@(posedge clk) disable iff (rst)
        wr_count |=> (count == $past(bus_wdata[CNT_W-1:0])));
endmodule

// File: tb/tmr_channel_bench.sv
module tmr_channel_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] A_PER = 4'h0, A_CNT = 4'h4, A_CTL = 4'h8, A_INT = 4'hC;
    localparam logic [31:0] EN = 32'h1000_0000, RPT = 32'h0100_0000;
    localparam logic [31:0] IE = 32'h0010_0000, PND = 32'h0001_0000;

    typedef struct packed {
        logic [31:0] period;
        logic [31:0] div;
        logic        rpt;
        logic [31:0] wait_n;
        logic [31:0] exp_cnt;
        logic        exp_pend;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'd100, 32'd2, 1'b1, 32'd10, 32'd5, 1'b0},
        '{32'd100, 32'd3, 1'b1, 32'd31, 32'd10, 1'b0},
        '{32'd4,   32'd2, 1'b1, 32'd8,  32'd0, 1'b1},
        '{32'd4,   32'd2, 1'b1, 32'd11, 32'd1, 1'b1},
        '{32'd50,  32'd0, 1'b1, 32'd9,  32'd4, 1'b0},
        '{32'd50,  32'd1, 1'b1, 32'd9,  32'd4, 1'b0},
        '{32'd50,  32'd5, 1'b1, 32'd23, 32'd4, 1'b0},
        '{32'd4,   32'd2, 1'b0, 32'd20, 32'd3, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_channel u_tmr_channel (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [31:0] v, v0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R11 reset state
        rd(A_PER, v); chk("R11 period", v, 0);
        rd(A_CNT, v); chk("R11 count", v, 0);
        rd(A_CTL, v); chk("R11 ctrl", v, 0);
        rd(A_INT, v); chk("R11 intr", v, 0);
        chk("R11 irq", {31'd0, irq}, 0);

        // R1 readback with unused bits zero
        wr(A_PER, 32'hFFFF_FFFF); rd(A_PER, v); chk("R1 period mask", v, 32'h0FFF_FFFF);
        wr(A_CTL, 32'hFFFF_FFFF); rd(A_CTL, v); chk("R1 ctrl mask", v, 32'h1100_FFFF);
        wr(A_CTL, 0);             rd(A_CTL, v); chk("R2 ctrl zero", v, 0);

        // vector table: R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            wr(A_CTL, 0);
            wr(A_INT, PND);
            wr(A_CNT, 0);
            wr(A_PER, VECS[i].period);
            wr(A_CTL, EN | (VECS[i].rpt ? RPT : 32'd0) | VECS[i].div);
            repeat (VECS[i].wait_n) @(posedge clk);
            #1;
            rd(A_CNT, v); chk("R3/R5/R6 count", v, VECS[i].exp_cnt);
            rd(A_INT, v); chk("R4 pending", {31'd0, v[16]}, {31'd0, VECS[i].exp_pend});
        end
        // R6 one-shot cleared the enable (last vector)
        rd(A_CTL, v); chk("R6 enable cleared", v, 32'h0000_0002);
        // R2 stopped count stays put
        rd(A_CNT, v0); repeat (20) @(posedge clk); #1;
        rd(A_CNT, v); chk("R2 frozen", v, v0);

        // R7 and R8: enable gating and write-one-to-clear
        chk("R7 irq masked", {31'd0, irq}, 0);
        wr(A_INT, IE);
        rd(A_INT, v); chk("R8 zero keeps pend", v, IE | PND);
        chk("R7 irq raised", {31'd0, irq}, 1);
        wr(A_INT, IE | PND);
        rd(A_INT, v); chk("R8 cleared", v, IE);
        chk("R7 irq dropped", {31'd0, irq}, 0);

        // R9: clear write on the expiry edge (P=4, D=2 -> edge 8)
        wr(A_CTL, 0);
        wr(A_INT, IE | PND);
        wr(A_CNT, 0);
        wr(A_PER, 4);
        wr(A_CTL, EN | RPT | 32'd2);
        repeat (7) @(posedge clk);
        wr(A_INT, IE | PND);
        rd(A_INT, v); chk("R9 set wins", v, IE | PND);
        chk("R9 irq", {31'd0, irq}, 1);

        // R10: load while running restarts the prescaler phase
        wr(A_CTL, 0);
        wr(A_INT, PND);
        wr(A_CNT, 0);
        wr(A_PER, 1000);
        wr(A_CTL, EN | RPT | 32'd4);
        repeat (9) @(posedge clk);
        wr(A_CNT, 20);
        rd(A_CNT, v); chk("R10 loaded", v, 20);
        repeat (2) @(posedge clk); #1;
        rd(A_CNT, v); chk("R10 phase restart", v, 20);
        repeat (2) @(posedge clk); #1;
        rd(A_CNT, v); chk("R10 next tick", v, 21);

        finish_run();
    end
endmodule